// File: doc/BRIEF.md
# Multi-channel transceiver analog settings writer

This block keeps the analog settings of several serial transceiver channels and updates one addressed channel at a time. A write presents four control values: a 3-bit output swing, a 5-bit pre-emphasis, a 2-bit equalizer DC gain and a 4-bit equalizer control. It also presents a channel number and a 2-bit direction code that picks which of those fields the write touches. A single-cycle strobe starts the write.

On the strobe cycle the controller takes a copy of every input. It then moves the selected fields into the addressed channel's settings over a narrow internal write path that carries one field per cycle. A busy flag stays high for the whole update. A strobe that cannot be accepted raises a one-cycle error pulse and changes nothing. This happens when a write is already running or when the channel number is out of range. Any channel's current settings can be read at any time through a separate read port.

Top module: `xcvr_cfg_writer`

## Requirements
- R1: Each channel stores swing (3 bits), pre-emphasis (5 bits), DC gain (2 bits) and equalizer control (4 bits). These widths do not depend on NCH. All stored fields read as zero after reset, and busy and err are low.
- R2: A strobe sampled while busy is low, with chan_in below NCH and dir_in not 2'b00, starts a write. busy is high in the cycle after the strobe.
- R3: The dir_in codes work as follows. 2'b10 writes only swing and pre-emphasis. 2'b01 writes only DC gain and equalizer control. 2'b11 writes all four fields. Fields that are not selected keep their stored values.
- R4: A strobe with dir_in = 2'b00 and a valid channel raises neither busy nor err, and no stored value changes.
- R5: Selected fields are written one per cycle in this fixed order: swing, pre-emphasis, DC gain, equalizer control. busy stays high for (number of selected fields + 1) cycles.
- R6: A strobe that arrives while busy is high is ignored. err is high for exactly the one cycle after it, and the write in progress finishes unchanged.
- R7: A strobe with chan_in at or above NCH is rejected. err is high in the next cycle, busy stays low, and no channel changes.
- R8: The data, channel and direction inputs are captured on the strobe cycle. Changes to them while busy is high have no effect on the write.
- R9: A write changes only the addressed channel. Every other channel keeps its values.
- R10: The rd_* outputs show the stored fields of channel rd_chan (valid for rd_chan below NCH) combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swing_in | input | 3 | Output swing value to write |
| preemph_in | input | 5 | Pre-emphasis value to write |
| dcgain_in | input | 2 | Equalizer DC gain value to write |
| eqctl_in | input | 4 | Equalizer control value to write |
| chan_in | input | AW | Channel to update |
| dir_in | input | 2 | Field group select: 01 receive, 10 transmit, 11 both |
| wr_stb | input | 1 | One-cycle write start |
| busy | output | 1 | Write in progress |
| err | output | 1 | One-cycle pulse on a rejected strobe |
| rd_chan | input | AW | Channel to read back |
| rd_swing | output | 3 | Stored swing of rd_chan |
| rd_preemph | output | 5 | Stored pre-emphasis of rd_chan |
| rd_dcgain | output | 2 | Stored DC gain of rd_chan |
| rd_eqctl | output | 4 | Stored equalizer control of rd_chan |

## Verification
A table of writes covers every channel and all three active direction codes. Each entry carries distinct field values, so a field written to the wrong channel, or a field outside the selected group, shows up when all channels are read back. Directed cases sample the read port on each busy cycle of a full write to show the field order. They scramble the inputs and strobe again mid-write to show capture and rejection. They also drive an out-of-range channel and the empty direction code to show that nothing moves.

// File: rtl/xcvr_cfg_writer.sv
module xcvr_cfg_writer #(
  parameter int NCH = 3,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    swing_in,
  input  logic [4:0]    preemph_in,
  input  logic [1:0]    dcgain_in,
  input  logic [3:0]    eqctl_in,
  input  logic [AW-1:0] chan_in,
  input  logic [1:0]    dir_in,
  input  logic          wr_stb,
  output logic          busy,
  output logic          err,
  input  logic [AW-1:0] rd_chan,
  output logic [2:0]    rd_swing,
  output logic [4:0]    rd_preemph,
  output logic [1:0]    rd_dcgain,
  output logic [3:0]    rd_eqctl
);

  logic [AW-1:0] cap_chan;
  logic [2:0]    cap_sw;
  logic [4:0]    cap_pe;
  logic [1:0]    cap_dc;
  logic [3:0]    cap_eq;
  logic [3:0]    pend;

  logic [2:0] sw_q [NCH];
  logic [4:0] pe_q [NCH];
  logic [1:0] dc_q [NCH];
  logic [3:0] eq_q [NCH];

  logic       bus_we;
  logic [1:0] bus_fld;
  logic [4:0] bus_dat;

  wire chan_ok = 32'(chan_in) < NCH;
  wire start   = wr_stb && !busy && chan_ok && (dir_in != 2'b00);

  assign bus_we  = busy && (pend != 4'b0);
  assign bus_fld = pend[0] ? 2'd0 : pend[1] ? 2'd1 : pend[2] ? 2'd2 : 2'd3;

  always_comb begin
    case (bus_fld)
      2'd0:    bus_dat = {2'b00, cap_sw};
      2'd1:    bus_dat = cap_pe;
      2'd2:    bus_dat = {3'b000, cap_dc};
      default: bus_dat = {1'b0, cap_eq};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err      <= 1'b0;
      pend     <= 4'b0;
      cap_chan <= '0;
      cap_sw   <= '0;
      cap_pe   <= '0;
      cap_dc   <= '0;
      cap_eq   <= '0;
    end else begin
      err <= wr_stb && (busy || !chan_ok);
      if (start) begin
        busy     <= 1'b1;
        pend     <= {dir_in[0], dir_in[0], dir_in[1], dir_in[1]};
        cap_chan <= chan_in;
        cap_sw   <= swing_in;
        cap_pe   <= preemph_in;
        cap_dc   <= dcgain_in;
        cap_eq   <= eqctl_in;
      end else if (busy) begin
        if (pend != 4'b0) pend[bus_fld] <= 1'b0;
        else              busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        sw_q[i] <= '0;
        pe_q[i] <= '0;
        dc_q[i] <= '0;
        eq_q[i] <= '0;
      end
    end else if (bus_we) begin
      case (bus_fld)
        2'd0:    sw_q[cap_chan] <= bus_dat[2:0];
        2'd1:    pe_q[cap_chan] <= bus_dat;
        2'd2:    dc_q[cap_chan] <= bus_dat[1:0];
        default: eq_q[cap_chan] <= bus_dat[3:0];
      endcase
    end
  end

  assign rd_swing   = sw_q[rd_chan];
  assign rd_preemph = pe_q[rd_chan];
  assign rd_dcgain  = dc_q[rd_chan];
  assign rd_eqctl   = eq_q[rd_chan];

endmodule

// File: rtl/xcvr_cfg_writer_chk.sv
module xcvr_cfg_writer_chk #(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic          busy,
  input logic          err,
  input logic [AW-1:0] chan_in,
  input logic [1:0]    dir_in
);

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !busy && (32'(chan_in) < NCH) && dir_in != 2'b00) |=> (busy && !err));

  a_r4_empty_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !busy && (32'(chan_in) < NCH) && dir_in == 2'b00) |=> (!busy && !err));

  a_r6_busy_strobe_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && busy) |=> err);

  a_r7_bad_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !busy && (32'(chan_in) >= NCH)) |=> (err && !busy));

  a_r6_err_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> !err);

endmodule

bind xcvr_cfg_writer xcvr_cfg_writer_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .busy(busy), .err(err),
  .chan_in(chan_in), .dir_in(dir_in)
);

// File: tb/xcvr_cfg_writer_tb_top.sv
module xcvr_cfg_writer_tb_top;
  localparam int NCH = 3;
  localparam int AW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] swing_in = '0;
  logic [4:0] preemph_in = '0;
  logic [1:0] dcgain_in = '0;
  logic [3:0] eqctl_in = '0;
  logic [AW-1:0] chan_in = '0;
  logic [1:0] dir_in = '0;
  logic wr_stb = 1'b0;
  logic busy, err;
  logic [AW-1:0] rd_chan = '0;
  logic [2:0] rd_swing;
  logic [4:0] rd_preemph;
  logic [1:0] rd_dcgain;
  logic [3:0] rd_eqctl;

  always #2.5 clk = ~clk;

  xcvr_cfg_writer #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .swing_in(swing_in), .preemph_in(preemph_in),
    .dcgain_in(dcgain_in), .eqctl_in(eqctl_in), .chan_in(chan_in), .dir_in(dir_in),
    .wr_stb(wr_stb), .busy(busy), .err(err), .rd_chan(rd_chan), .rd_swing(rd_swing),
    .rd_preemph(rd_preemph), .rd_dcgain(rd_dcgain), .rd_eqctl(rd_eqctl)
  );

  int n_chk = 0;
  int n_fail = 0;

  int m_sw [NCH];
  int m_pe [NCH];
  int m_dc [NCH];
  int m_eq [NCH];

  // {chan[2], dir[2], swing[3], preemph[5], dcgain[2], eqctl[4]}
  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 2'b11, 3'd5, 5'd19, 2'd2, 4'd9},
    {2'd1, 2'b10, 3'd3, 5'd27, 2'd1, 4'd6},
    {2'd2, 2'b01, 3'd7, 5'd4,  2'd3, 4'd12},
    {2'd1, 2'b01, 3'd2, 5'd8,  2'd2, 4'd5},
    {2'd2, 2'b11, 3'd1, 5'd31, 2'd1, 4'd15},
    {2'd0, 2'b10, 3'd6, 5'd10, 2'd3, 4'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++) begin
      rd_chan = AW'(c);
      #0.5;
      chk(int'(rd_swing) == m_sw[c], {req, " swing"}, rd_swing, m_sw[c]);
      chk(int'(rd_preemph) == m_pe[c], {req, " preemph"}, rd_preemph, m_pe[c]);
      chk(int'(rd_dcgain) == m_dc[c], {req, " dcgain"}, rd_dcgain, m_dc[c]);
      chk(int'(rd_eqctl) == m_eq[c], {req, " eqctl"}, rd_eqctl, m_eq[c]);
    end
  endtask

  task automatic model_write(input int c, input logic [1:0] d, input int sw, input int pe,
                             input int dc, input int eq);
    if (d[1]) begin m_sw[c] = sw; m_pe[c] = pe; end
    if (d[0]) begin m_dc[c] = dc; m_eq[c] = eq; end
  endtask

  task automatic strobe(input int c, input logic [1:0] d, input int sw, input int pe,
                        input int dc, input int eq);
    @(negedge clk);
    chan_in = AW'(c); dir_in = d; swing_in = 3'(sw); preemph_in = 5'(pe);
    dcgain_in = 2'(dc); eqctl_in = 4'(eq); wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  function automatic int nfields(input logic [1:0] d);
    return (d[1] ? 2 : 0) + (d[0] ? 2 : 0);
  endfunction

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int blen;
    for (int c = 0; c < NCH; c++) begin m_sw[c] = 0; m_pe[c] = 0; m_dc[c] = 0; m_eq[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(err == 1'b0, "R1 reset err", err, 0);
    check_all("R1 reset");

    // table walk: R2 R3 R5 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      logic [17:0] e;
      e = VEC[v];
      strobe(int'(e[17:16]), e[15:14], int'(e[13:11]), int'(e[10:6]), int'(e[5:4]), int'(e[3:0]));
      chk(busy == 1'b1, "R2 busy after strobe", busy, 1);
      busy_len(blen);
      chk(blen == nfields(e[15:14]) + 1, "R5 busy length", blen, nfields(e[15:14]) + 1);
      model_write(int'(e[17:16]), e[15:14], int'(e[13:11]), int'(e[10:6]), int'(e[5:4]), int'(e[3:0]));
      check_all("R3 R9 R10 table");
    end

    // R5 field order on a full write to channel 1
    rd_chan = AW'(1);
    strobe(1, 2'b11, 4, 17, 3, 10);
    #0.5;
    chk(int'(rd_swing) == m_sw[1], "R5 order c0 swing old", rd_swing, m_sw[1]);
    @(negedge clk); #0.5;
    chk(rd_swing == 3'd4, "R5 order c1 swing new", rd_swing, 4);
    chk(int'(rd_preemph) == m_pe[1], "R5 order c1 preemph old", rd_preemph, m_pe[1]);
    @(negedge clk); #0.5;
    chk(rd_preemph == 5'd17, "R5 order c2 preemph new", rd_preemph, 17);
    chk(int'(rd_dcgain) == m_dc[1], "R5 order c2 dcgain old", rd_dcgain, m_dc[1]);
    @(negedge clk); #0.5;
    chk(rd_dcgain == 2'd3, "R5 order c3 dcgain new", rd_dcgain, 3);
    chk(int'(rd_eqctl) == m_eq[1], "R5 order c3 eqctl old", rd_eqctl, m_eq[1]);
    @(negedge clk); #0.5;
    chk(rd_eqctl == 4'd10, "R5 order c4 eqctl new", rd_eqctl, 10);
    chk(busy == 1'b1, "R5 finish cycle busy", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R5 busy dropped", busy, 0);
    model_write(1, 2'b11, 4, 17, 3, 10);

    // R8 and R6: scramble inputs and strobe again mid-write
    strobe(2, 2'b11, 2, 6, 1, 3);
    chan_in = AW'(0); dir_in = 2'b10; swing_in = 3'd7; preemph_in = 5'd31;
    dcgain_in = 2'd0; eqctl_in = 4'd0;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(err == 1'b1, "R6 err on busy strobe", err, 1);
    @(negedge clk);
    chk(err == 1'b0, "R6 err single cycle", err, 0);
    busy_len(blen);
    chk(blen == 3, "R6 busy remaining cycles", blen, 3);
    model_write(2, 2'b11, 2, 6, 1, 3);
    check_all("R8 R6 captured values");

    // R7 out-of-range channel
    strobe(3, 2'b11, 1, 1, 1, 1);
    chk(err == 1'b1, "R7 err on bad chan", err, 1);
    chk(busy == 1'b0, "R7 busy stays low", busy, 0);
    @(negedge clk);
    chk(err == 1'b0, "R7 err pulse ends", err, 0);
    check_all("R7 no change");

    // R4 empty direction
    strobe(0, 2'b00, 1, 1, 1, 1);
    chk(busy == 1'b0, "R4 no busy", busy, 0);
    chk(err == 1'b0, "R4 no err", err, 0);
    @(negedge clk);
    chk(busy == 1'b0, "R4 still idle", busy, 0);
    check_all("R4 no change");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule